// File: doc/BRIEF.md
# Rotating-Priority Serial Bus Arbiter

This block decides which of a set of interrupt agents may use a shared serial message bus on which a driven 1 overrides a driven 0. Every agent owns a distinct arbitration rank, from 0 (weakest) up to the number of agents minus one (strongest). When at least one agent asks for the bus, the block runs a round of bit-serial arbitration: each cycle all remaining contenders drive one bit onto a wired-OR line, and any contender that drove 0 while the line reads 1 withdraws. The survivor of the last cycle is granted the bus and keeps it until the transfer-done strobe arrives.

A contender may flag its message as an end-of-interrupt. The round then opens with an extra cycle in which those flags are driven, so a flagged message beats every unflagged one, and several flagged contenders are settled among themselves by rank. When a transfer completes, the ranks rotate: the sender drops to 0, every other agent moves up by one, and the agent that held the top rank without sending takes the sender's old rank plus one. The ranks therefore remain a permutation at all times.

Top module: `rot_serial_arbiter`

## Requirements
- R1: After reset, agent i holds rank i (read from `prio_o[i*PRIO_W +: PRIO_W]`) and `grant_o` is all zeros.
- R2: While no agent requests the bus, no grant is issued and every rank stays unchanged.
- R3: With the end-of-interrupt option on, `grant_o` becomes non-zero after the PRIO_W+2nd rising edge, counting the edge that first samples a non-empty request; it is then exactly one-hot.
- R4: When no requester raises its end-of-interrupt flag, the requester with the highest rank is granted.
- R5: A single requester that raises its end-of-interrupt flag is granted, whatever its rank and however many other agents request.
- R6: When several requesters raise their end-of-interrupt flags, the one with the highest rank among them is granted.
- R7: Requests and flags are sampled only at the start of a round; the grant stays unchanged until the done strobe, whatever the request inputs do meanwhile.
- R8: On the done strobe during a grant, the granted agent takes rank 0 and the grant is withdrawn on the next cycle.
- R9: On the same strobe, an agent that held the top rank without sending takes the sender's old rank plus one; every other agent's rank increases by one.
- R10: The ranks form a permutation of 0 to N_AGENTS-1 in every cycle.
- R11: A done strobe outside a grant changes no rank and causes no grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_AGENTS | Per-agent bus request |
| eoi_i | input | N_AGENTS | Per-agent end-of-interrupt flag for the requested message |
| done_i | input | 1 | Transfer-done strobe from the current bus owner |
| grant_o | output | N_AGENTS | One-hot bus grant, zero when the bus is free |
| prio_o | output | N_AGENTS*PRIO_W | Current rank of each agent, agent i in bits [i*PRIO_W +: PRIO_W] |

## Verification
On every cycle the assertions check that the ranks stay a permutation, that a grant is one-hot, that the winner outranks every requester of its own flag class, that a flagged requester wins whenever one exists, and that ranks move only on a completing strobe and then by the rotation rules. The exact latency from request to grant, the precise identity of the winner for a given request pattern, and the insensitivity to request changes mid-round only show up in the bench's scenarios, which compare each grant and each rank update with a rank model kept in the bench over directed and long pseudo-random request sequences.

// File: rtl/rsa_pkg.sv
package rsa_pkg;

   typedef enum logic [1:0] {
      RSA_IDLE = 2'd0,
      RSA_ARB  = 2'd1,
      RSA_GNT  = 2'd2
   } rsa_state_e;

endpackage

// File: rtl/rsa_seq.sv
module rsa_seq
   import rsa_pkg::*;
#(
   parameter int NSTAGE = 5,
   localparam int SW = (NSTAGE > 1) ? $clog2(NSTAGE) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_req_i,
   input  logic          done_i,
   output rsa_state_e    state_o,
   output logic [SW-1:0] stage_o,
   output logic          start_o,
   output logic          step_o,
   output logic          commit_o
);

   localparam logic [SW-1:0] LAST_STAGE = SW'(NSTAGE - 1);

   rsa_state_e    state_q;
   logic [SW-1:0] stage_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RSA_IDLE;
         stage_q <= '0;
      end else begin
         case (state_q)
            RSA_IDLE: begin
               if (any_req_i) begin
                  state_q <= RSA_ARB;
                  stage_q <= '0;
               end
            end
            RSA_ARB: begin
               if (stage_q == LAST_STAGE) begin
                  state_q <= RSA_GNT;
                  stage_q <= '0;
               end else begin
                  stage_q <= stage_q + SW'(1);
               end
            end
            RSA_GNT: begin
               if (done_i) begin
                  state_q <= RSA_IDLE;
               end
            end
            default: begin
               state_q <= RSA_IDLE;
               stage_q <= '0;
            end
         endcase
      end
   end

   assign state_o  = state_q;
   assign stage_o  = stage_q;
   assign start_o  = (state_q == RSA_IDLE) && any_req_i;
   assign step_o   = (state_q == RSA_ARB);
   assign commit_o = (state_q == RSA_GNT) && done_i;

   // R3: the round lasts exactly NSTAGE arbitration cycles
   a_r3_round_len : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RSA_ARB && stage_q == LAST_STAGE) |=> (state_q == RSA_GNT));

   // R7: the grant phase is left only through the done strobe
   a_r7_hold_grant : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RSA_GNT && !done_i) |=> (state_q == RSA_GNT));

   // R2: no request keeps the sequencer idle
   a_r2_stay_idle : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == RSA_IDLE && !any_req_i) |=> (state_q == RSA_IDLE));

endmodule

// File: rtl/rsa_lane.sv
module rsa_lane #(
   parameter int PRIO_W     = 4,
   parameter int EOI_EN     = 1,
   parameter int RESET_PRIO = 0,
   localparam int BIW = (PRIO_W > 1) ? $clog2(PRIO_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              req_i,
   input  logic              eoi_i,
   input  logic              step_i,
   input  logic              sel_eoi_i,
   input  logic [BIW-1:0]    bit_idx_i,
   input  logic              bus_i,
   input  logic              commit_i,
   input  logic [PRIO_W-1:0] win_prio_i,
   input  logic              any_eoi_i,
   input  logic              grant_phase_i,
   output logic              drive_o,
   output logic              contend_o,
   output logic              cand_eoi_o,
   output logic [PRIO_W-1:0] prio_o
);

   localparam logic [PRIO_W-1:0] TOP_RANK = {PRIO_W{1'b1}};

   logic              contend_q;
   logic              req_q;
   logic              eoi_q;
   logic [PRIO_W-1:0] prio_q;
   logic              own_bit;

   generate
      if (EOI_EN != 0) begin : g_eoi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               eoi_q <= 1'b0;
            end else if (start_i) begin
               eoi_q <= eoi_i;
            end
         end
      end else begin : g_no_eoi
         assign eoi_q = 1'b0;
      end
   endgenerate

   assign own_bit = sel_eoi_i ? eoi_q : prio_q[bit_idx_i];
   assign drive_o = contend_q & own_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         contend_q <= 1'b0;
         req_q     <= 1'b0;
      end else if (start_i) begin
         contend_q <= req_i;
         req_q     <= req_i;
      end else if (commit_i) begin
         contend_q <= 1'b0;
         req_q     <= 1'b0;
      end else if (step_i && contend_q && !own_bit && bus_i) begin
         contend_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= PRIO_W'(RESET_PRIO);
      end else if (commit_i) begin
         if (contend_q) begin
            prio_q <= '0;
         end else if (prio_q == TOP_RANK) begin
            prio_q <= win_prio_i + PRIO_W'(1);
         end else begin
            prio_q <= prio_q + PRIO_W'(1);
         end
      end
   end

   assign contend_o  = contend_q;
   assign cand_eoi_o = req_q & eoi_q;
   assign prio_o     = prio_q;

   // R8: the sender falls to rank zero
   a_r8_sender_zero : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && contend_q) |=> (prio_q == '0));

   // R9: the top-ranked loser takes the sender's rank plus one
   a_r9_top_loser : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !contend_q && prio_q == TOP_RANK)
      |=> (prio_q == PRIO_W'($past(win_prio_i) + 1'b1)));

   // R9: every other loser moves up by one
   a_r9_step_up : assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && !contend_q && prio_q != TOP_RANK)
      |=> (prio_q == PRIO_W'($past(prio_q) + 1'b1)));

   // R11: ranks move only on a completing strobe
   a_r11_rank_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(prio_q));

   // R7: a withdrawn contender stays out until the next round
   a_r7_no_rejoin : assert property (@(posedge clk) disable iff (!rst_n)
      (!contend_q && !start_i) |=> !contend_q);

   // R4, R6: no requester of the winner's class outranks the winner
   a_r4_winner_max : assert property (@(posedge clk) disable iff (!rst_n)
      (grant_phase_i && req_q && (eoi_q == any_eoi_i)) |-> (prio_q <= win_prio_i));

endmodule

// File: rtl/rot_serial_arbiter.sv
module rot_serial_arbiter
   import rsa_pkg::*;
#(
   parameter int N_AGENTS = 16,
   parameter int EOI_EN   = 1,
   localparam int PRIO_W  = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_AGENTS-1:0]        req_i,
   input  logic [N_AGENTS-1:0]        eoi_i,
   input  logic                       done_i,
   output logic [N_AGENTS-1:0]        grant_o,
   output logic [N_AGENTS*PRIO_W-1:0] prio_o
);

   localparam int NSTAGE = PRIO_W + ((EOI_EN != 0) ? 1 : 0);
   localparam int SW     = (NSTAGE > 1) ? $clog2(NSTAGE) : 1;
   localparam int BIW    = (PRIO_W > 1) ? $clog2(PRIO_W) : 1;
   localparam int LEAD   = (EOI_EN != 0) ? 1 : 0;

   generate
      if (N_AGENTS < 4) begin : g_cfg_small
         $error("rot_serial_arbiter: N_AGENTS must be at least 4");
      end
      if ((1 << PRIO_W) != N_AGENTS) begin : g_cfg_pow2
         $error("rot_serial_arbiter: N_AGENTS must be a power of two");
      end
      if (EOI_EN != 0 && EOI_EN != 1) begin : g_cfg_eoi
         $error("rot_serial_arbiter: EOI_EN must be 0 or 1");
      end
   endgenerate

   rsa_state_e          state;
   logic [SW-1:0]       stage;
   logic                start;
   logic                step;
   logic                commit;
   logic                sel_eoi;
   logic [BIW-1:0]      bit_idx;
   logic                bus_bit;
   logic                any_eoi;
   logic                grant_phase;
   logic [PRIO_W-1:0]   win_prio;
   logic [N_AGENTS-1:0] drive;
   logic [N_AGENTS-1:0] contend;
   logic [N_AGENTS-1:0] cand_eoi;
   logic [PRIO_W-1:0]   rank [N_AGENTS];

   rsa_seq #(
      .NSTAGE (NSTAGE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_req_i (|req_i),
      .done_i    (done_i),
      .state_o   (state),
      .stage_o   (stage),
      .start_o   (start),
      .step_o    (step),
      .commit_o  (commit)
   );

   assign sel_eoi     = (EOI_EN != 0) && (stage == '0);
   assign bit_idx     = BIW'(PRIO_W - 1 + LEAD - int'(stage));
   assign bus_bit     = |drive;
   assign any_eoi     = |cand_eoi;
   assign grant_phase = (state == RSA_GNT);
   assign grant_o     = grant_phase ? contend : '0;

   always_comb begin
      win_prio = '0;
      for (int k = 0; k < N_AGENTS; k++) begin
         if (grant_o[k]) begin
            win_prio = win_prio | rank[k];
         end
      end
   end

   for (genvar i = 0; i < N_AGENTS; i++) begin : g_lane
      rsa_lane #(
         .PRIO_W     (PRIO_W),
         .EOI_EN     (EOI_EN),
         .RESET_PRIO (i)
      ) u_lane (
         .clk           (clk),
         .rst_n         (rst_n),
         .start_i       (start),
         .req_i         (req_i[i]),
         .eoi_i         (eoi_i[i]),
         .step_i        (step),
         .sel_eoi_i     (sel_eoi),
         .bit_idx_i     (bit_idx),
         .bus_i         (bus_bit),
         .commit_i      (commit),
         .win_prio_i    (win_prio),
         .any_eoi_i     (any_eoi),
         .grant_phase_i (grant_phase),
         .drive_o       (drive[i]),
         .contend_o     (contend[i]),
         .cand_eoi_o    (cand_eoi[i]),
         .prio_o        (rank[i])
      );
      assign prio_o[i*PRIO_W +: PRIO_W] = rank[i];
   end

   logic [N_AGENTS-1:0] occupied;
   always_comb begin
      occupied = '0;
      for (int k = 0; k < N_AGENTS; k++) begin
         occupied[rank[k]] = 1'b1;
      end
   end

   // R10: every rank value is held by some agent
   a_r10_perm : assert property (@(posedge clk) disable iff (!rst_n)
      (&occupied));

   // R3: a grant names exactly one agent
   a_r3_onehot : assert property (@(posedge clk) disable iff (!rst_n)
      grant_phase |-> ($countones(grant_o) == 1));

   // R5: a flagged requester always takes the bus over unflagged ones
   a_r5_eoi_wins : assert property (@(posedge clk) disable iff (!rst_n)
      (grant_phase && any_eoi) |-> (|(grant_o & cand_eoi)));

   // R8: the grant is withdrawn after the completing strobe
   a_r8_release : assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (grant_o == '0));

endmodule

// File: tb/test_rot_serial_arbiter.sv
`timescale 1ns/1ps
module test_rot_serial_arbiter;

   localparam int N  = 16;
   localparam int W  = 4;
   localparam int LAT = W + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] eoi = '0;
   logic         done = 1'b0;
   logic [N-1:0] grant_o;
   logic [N*W-1:0] prio_o;

   int tests = 0;
   int fails = 0;
   int mp [N];
   logic [15:0] lfsr = 16'hACE1;

   always #2 clk = ~clk;

   rot_serial_arbiter #(.N_AGENTS(N), .EOI_EN(1)) i_rot_serial_arbiter (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .eoi_i   (eoi),
      .done_i  (done),
      .grant_o (grant_o),
      .prio_o  (prio_o)
   );

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int rank_of(input int i);
      return int'(prio_o[i*W +: W]);
   endfunction

   task automatic check_ranks(input string tag);
      bit ok = 1'b1;
      bit [N-1:0] seen = '0;
      for (int i = 0; i < N; i++) begin
         if (rank_of(i) != mp[i]) ok = 1'b0;
         seen[rank_of(i)] = 1'b1;
      end
      check(ok, tag, prio_o, 0);
      check(&seen, "R10 permutation", seen, {N{1'b1}});
   endtask

   function automatic int ref_winner(input logic [N-1:0] r, input logic [N-1:0] e);
      int w = -1;
      int best = -1;
      bit fl = |(r & e);
      for (int i = 0; i < N; i++) begin
         if (r[i] && (!fl || e[i]) && mp[i] > best) begin
            best = mp[i];
            w = i;
         end
      end
      return w;
   endfunction

   function automatic logic [15:0] next_lfsr(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   // one complete round; bus inputs change at negedges only
   task automatic run_round(input logic [N-1:0] r, input logic [N-1:0] e, input bit stray_done);
      int w;
      int lat;
      int wp;
      string tag;
      logic [N-1:0] g0;
      @(negedge clk);
      req = r;
      eoi = e;
      if (r == '0) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(grant_o == '0, "R2 no grant", grant_o, 0);
         end
         check_ranks("R2 ranks unchanged");
         return;
      end
      w = ref_winner(r, e);
      if ($countones(r & e) > 1) tag = "R6";
      else if ($countones(r & e) == 1) tag = "R5";
      else tag = "R4";
      lat = 0;
      while (grant_o == '0 && lat < 20) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (lat == 1) begin
            req = ~r;                // R7: changes after sampling are ignored
            eoi = ~e;
            if (stray_done) done = 1'b1;   // R11: strobe during arbitration
         end else begin
            done = 1'b0;
         end
      end
      done = 1'b0;
      check(lat == LAT, "R3 latency", lat, LAT);
      check(grant_o == (N'(1) << w), tag, grant_o, N'(1) << w);
      g0 = grant_o;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         check(grant_o == g0, "R7 grant held", grant_o, g0);
      end
      check_ranks("R11 ranks held during round");
      done = 1'b1;
      req = '0;
      eoi = '0;
      @(negedge clk);
      done = 1'b0;
      wp = mp[w];
      for (int i = 0; i < N; i++) begin
         if (i == w) mp[i] = 0;
         else if (mp[i] == N - 1) mp[i] = wp + 1;
         else mp[i] = mp[i] + 1;
      end
      check(grant_o == '0, "R8 grant released", grant_o, 0);
      check(rank_of(w) == 0, "R8 sender rank", rank_of(w), 0);
      check_ranks("R9 rank rotation");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [N-1:0] all_lo;
      for (int i = 0; i < N; i++) mp[i] = i;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(grant_o == '0, "R1 reset grant", grant_o, 0);
      check_ranks("R1 reset ranks");

      run_round('0, '0, 1'b0);                   // R2
      @(negedge clk); done = 1'b1;                // R11: strobe while idle
      @(negedge clk); done = 1'b0;
      @(negedge clk);
      check(grant_o == '0, "R11 idle strobe grant", grant_o, 0);
      check_ranks("R11 idle strobe ranks");

      run_round('1, '0, 1'b0);                    // R4: all request
      run_round(16'h0001, '0, 1'b1);              // single requester, stray strobe
      all_lo = '0;
      for (int i = 0; i < N; i++) if (mp[i] == 0) all_lo[i] = 1'b1;
      run_round('1, all_lo, 1'b0);                // R5: weakest flagged
      run_round('1, 16'h8421, 1'b0);              // R6: several flagged
      run_round(16'h00F0, 16'h0F00, 1'b0);        // flags on non-requesters

      // sweep: every agent in turn holds the top rank and all request
      for (int k = 0; k < N; k++) run_round('1, '0, 1'b0);

      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] r;
         logic [N-1:0] e;
         lfsr = next_lfsr(lfsr); r = lfsr;
         lfsr = next_lfsr(lfsr); e = lfsr & next_lfsr(lfsr) & next_lfsr(next_lfsr(lfsr));
         run_round(r, e, k[2]);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule